// File: doc/BRIEF.md
# DMA Completion Interrupt Coalescer

This block sits beside one channel of a descriptor-driven DMA engine and decides when that channel interrupts the processor. It receives a single-cycle pulse whenever the channel retires a descriptor, plus a pulse for channel errors. It keeps two pieces of state. The first is a completion counter that raises an interrupt after a programmable number of completions. The second is an inactivity timer that raises a separate interrupt when no further completion arrives within a programmable number of prescaled ticks. Each source has its own status bit and its own enable bit, and the status bits are cleared by writing ones.

The control word is held inside the block. The upper byte of the control word holds the inactivity delay and the byte below it holds the completion threshold. Bits 14:12 enable the interrupt sources and bit 0 is the run bit. When the control word is read back, its upper two bytes do not show the stored fields. They show the live completion counter and the live timer count, so software can see how far each mechanism has progressed.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After synchronous reset, `ctrl_rdata` reads 32'h0001_0000 (threshold, and therefore counter, equal to 1; timer 0), `irq_stat` is 0 and `irq` is low.
- R2: Each `desc_done` pulse lowers the completion counter by one, and the new value is visible in `ctrl_rdata[23:16]` in the next cycle.
- R3: When a completion pulse brings the counter to zero, status bit 12 (`irq_stat[0]`) is set and the counter reloads from the stored threshold field, control bits 23:16.
- R4: A completion pulse while the stored delay field (control bits 31:24) is nonzero loads the timer with that value, which discards any count in progress. When the delay field is zero, a completion leaves the timer unchanged.
- R5: A nonzero timer counts down once per prescaler tick, and a tick arrives every PRESCALE cycles. On reaching zero the timer sets status bit 13 (`irq_stat[1]`) and reloads the completion counter from the threshold. The timer then stays at zero.
- R6: `irq` is high exactly when some status bit among 14:12 is set together with the enable bit at the same position in the stored control word.
- R7: A status write clears each of bits 14:12 whose `stat_wclr` bit is 1, and a 0 in `stat_wclr` leaves that bit as it was.
- R8: If a set event and a clear of the same status bit fall in one cycle, the bit ends up set.
- R9: A control write with bit 0 set reloads the counter from the threshold byte being written. A control write with bit 0 clear leaves the counter unchanged.
- R10: `ctrl_rdata[15:0]` returns the low 16 bits of the last control write unchanged.
- R11: An `err_evt` pulse sets status bit 14 (`irq_stat[2]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| stat_we | input | 1 | Status write-one-to-clear strobe |
| stat_wclr | input | 3 | Clear mask for status bits 14:12 (LSB is bit 12) |
| desc_done | input | 1 | One-cycle pulse per completed descriptor |
| err_evt | input | 1 | One-cycle pulse per channel error |
| ctrl_rdata | output | 32 | Control readback: timer, counter, stored low half |
| irq_stat | output | 3 | Status bits 14:12 (LSB is bit 12) |
| irq | output | 1 | Channel interrupt line |

## Verification
The hardest situation to reach from the ports is a timer restart. The timer has to be reloaded while it is partway through counting, and the second load must be shown to have discarded the first. The bench programs a delay, waits a few ticks without letting the timer expire, and issues a second completion. It then measures the cycles from that second pulse to the delay interrupt, and that window excludes any expiry timed from the first pulse. Same-cycle set and clear is reached by arranging the counter at one and driving a completion together with the clear of that bit.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int CTRL_W   = 32;
    localparam int FIELD_W  = 8;
    localparam int LOW_W    = 16;
    localparam int NSRC     = 3;
    localparam int RUN_BIT  = 0;
    localparam int EN_LSB   = 12;

    typedef enum int {
        SRC_IOC = 0,
        SRC_DLY = 1,
        SRC_ERR = 2
    } irq_src_e;

    typedef struct packed {
        logic [FIELD_W-1:0] delay;
        logic [FIELD_W-1:0] thresh;
        logic [LOW_W-1:0]   low;
    } ctrl_word_t;

    localparam ctrl_word_t CTRL_RESET = '{delay: '0, thresh: 8'd1, low: '0};

    function automatic logic [NSRC-1:0] src_enables(input ctrl_word_t c);
        return c.low[EN_LSB +: NSRC];
    endfunction

    function automatic logic [CTRL_W-1:0] readback(
        input logic [FIELD_W-1:0] tmr,
        input logic [FIELD_W-1:0] cnt,
        input logic [LOW_W-1:0]   low
    );
        return {tmr, cnt, low};
    endfunction

endpackage

// File: rtl/dma_irq_tick.sv
module dma_irq_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || pre_q == LAST) pre_q <= '0;
                else                      pre_q <= pre_q + 1'b1;
            end

            assign tick = (pre_q == LAST);

            p_tick_spaced_r5: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dma_irq_thresh_cnt.sv
module dma_irq_thresh_cnt
    import dma_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_load,
    input  logic [FIELD_W-1:0] run_thr,
    input  logic               done,
    input  logic               expire,
    input  logic [FIELD_W-1:0] thr,
    output logic [FIELD_W-1:0] cnt_q,
    output logic               hit
);
    logic at_one;
    assign at_one = (cnt_q == FIELD_W'(1));
    assign hit    = done && !run_load && at_one;

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= CTRL_RESET.thresh;
        else if (run_load) cnt_q <= run_thr;
        else if (done)     cnt_q <= at_one ? thr : cnt_q - FIELD_W'(1);
        else if (expire)   cnt_q <= thr;
    end

    p_decrement_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !run_load && cnt_q > FIELD_W'(1)) |=> cnt_q == $past(cnt_q) - FIELD_W'(1));

    p_reload_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> cnt_q == $past(thr));

    p_run_reload_r9: assert property (@(posedge clk) disable iff (rst)
        run_load |=> cnt_q == $past(run_thr));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!run_load && !done && !expire) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_irq_delay.sv
module dma_irq_delay
    import dma_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  logic [FIELD_W-1:0] delay,
    input  logic               tick,
    output logic [FIELD_W-1:0] tmr_q,
    output logic               expire
);
    logic load;
    assign load   = done && (delay != '0);
    assign expire = !load && tick && (tmr_q == FIELD_W'(1));

    always_ff @(posedge clk) begin
        if (rst)                          tmr_q <= '0;
        else if (load)                    tmr_q <= delay;
        else if (tick && tmr_q != '0)     tmr_q <= tmr_q - FIELD_W'(1);
    end

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> tmr_q == $past(delay));

    p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && tmr_q != '0) |=> tmr_q == $past(tmr_q) - FIELD_W'(1));

    p_stop_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && tmr_q == '0) |=> tmr_q == '0);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] stat_q,
    output logic            irq
);
    logic [NSRC-1:0] clr_eff;
    assign clr_eff = clr_we ? clr : '0;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)             stat_q[i] <= 1'b0;
                else if (set[i])     stat_q[i] <= 1'b1;
                else if (clr_eff[i]) stat_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign irq = |(stat_q & en);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> (stat_q & $past(set)) == $past(set));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> (stat_q & $past(clr & ~set)) == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr_we && set == '0) |=> $stable(stat_q));
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
    import dma_irq_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              stat_we,
    input  logic [NSRC-1:0]   stat_wclr,
    input  logic              desc_done,
    input  logic              err_evt,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [NSRC-1:0]   irq_stat,
    output logic              irq
);
    ctrl_word_t         ctrl_q;
    ctrl_word_t         ctrl_in;
    logic               run_load;
    logic               tick;
    logic               hit;
    logic               expire;
    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] tmr_q;
    logic [NSRC-1:0]    set_vec;

    assign ctrl_in  = ctrl_word_t'(ctrl_wdata);
    assign run_load = ctrl_we && ctrl_wdata[RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= CTRL_RESET;
        else if (ctrl_we) ctrl_q <= ctrl_in;
    end

    dma_irq_tick #(.DIV(PRESCALE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dma_irq_thresh_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_load (run_load),
        .run_thr  (ctrl_in.thresh),
        .done     (desc_done),
        .expire   (expire),
        .thr      (ctrl_q.thresh),
        .cnt_q    (cnt_q),
        .hit      (hit)
    );

    dma_irq_delay u_dly (
        .clk    (clk),
        .rst    (rst),
        .done   (desc_done),
        .delay  (ctrl_q.delay),
        .tick   (tick),
        .tmr_q  (tmr_q),
        .expire (expire)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_IOC] = hit;
        set_vec[SRC_DLY] = expire;
        set_vec[SRC_ERR] = err_evt;
    end

    dma_irq_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .set    (set_vec),
        .clr_we (stat_we),
        .clr    (stat_wclr),
        .en     (src_enables(ctrl_q)),
        .stat_q (irq_stat),
        .irq    (irq)
    );

    assign ctrl_rdata = readback(tmr_q, cnt_q, ctrl_q.low);

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_rdata == 32'h0001_0000 && irq_stat == '0));

    p_low_half_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_rdata[LOW_W-1:0] == $past(ctrl_wdata[LOW_W-1:0]));

    p_err_sets_r11: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> irq_stat[SRC_ERR]);

    p_delay_sets_r5: assert property (@(posedge clk) disable iff (rst)
        expire |=> irq_stat[SRC_DLY]);
endmodule

// File: tb/dma_irq_coalescer_test.sv
module dma_irq_coalescer_test;

    typedef struct packed {
        logic [1:0]  op;      // 0 ctrl write, 1 completion, 2 status clear, 3 error
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [2:0]  exp_st;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0003_1001, 32'h0003_1001, 3'b000, 1'b0}, // R9 run reload
        '{2'd1, 32'h0,         32'h0002_1001, 3'b000, 1'b0}, // R2
        '{2'd1, 32'h0,         32'h0001_1001, 3'b000, 1'b0}, // R2
        '{2'd1, 32'h0,         32'h0003_1001, 3'b001, 1'b1}, // R3 R6
        '{2'd2, 32'h0000_0002, 32'h0003_1001, 3'b001, 1'b1}, // R7 zero leaves
        '{2'd2, 32'h0000_0001, 32'h0003_1001, 3'b000, 1'b0}, // R7 one clears
        '{2'd3, 32'h0,         32'h0003_1001, 3'b100, 1'b0}, // R11, R6 masked
        '{2'd0, 32'h0005_4000, 32'h0003_4000, 3'b100, 1'b1}, // R9 no run, R10
        '{2'd1, 32'h0,         32'h0002_4000, 3'b100, 1'b1}, // R2
        '{2'd0, 32'h0002_7001, 32'h0002_7001, 3'b100, 1'b1}, // R9
        '{2'd1, 32'h0,         32'h0001_7001, 3'b100, 1'b1}, // R2
        '{2'd1, 32'h0,         32'h0002_7001, 3'b101, 1'b1}, // R3
        '{2'd2, 32'h0000_0007, 32'h0002_7001, 3'b000, 1'b0}, // R7
        '{2'd0, 32'h0001_3000, 32'h0002_3000, 3'b000, 1'b0}, // R10
        '{2'd1, 32'h0,         32'h0001_3000, 3'b000, 1'b0}, // R2, R4 zero delay
        '{2'd1, 32'h0,         32'h0001_3000, 3'b001, 1'b1}  // R3 threshold one
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        stat_we = 1'b0;
    logic [2:0]  stat_wclr = '0;
    logic        desc_done = 1'b0;
    logic        err_evt = 1'b0;
    logic [31:0] ctrl_rdata;
    logic [2:0]  irq_stat;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    dma_irq_coalescer #(.PRESCALE(4)) uut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .stat_we    (stat_we),
        .stat_wclr  (stat_wclr),
        .desc_done  (desc_done),
        .err_evt    (err_evt),
        .ctrl_rdata (ctrl_rdata),
        .irq_stat   (irq_stat),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [31:0] data);
        @(negedge clk);
        case (op)
            2'd0: begin ctrl_we = 1'b1; ctrl_wdata = data; end
            2'd1: desc_done = 1'b1;
            2'd2: begin stat_we = 1'b1; stat_wclr = data[2:0]; end
            default: err_evt = 1'b1;
        endcase
        @(negedge clk);
        ctrl_we = 1'b0; desc_done = 1'b0; stat_we = 1'b0; err_evt = 1'b0;
    endtask

    task automatic wait_delay_irq(output int k);
        k = 0;
        while (irq_stat[1] !== 1'b1 && k < 60) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 readback", ctrl_rdata, 32'h0001_0000);
        chk("R1 status", {29'd0, irq_stat}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op, VECS[i].data);
            chk($sformatf("vector %0d readback (R2 R3 R9 R10)", i), ctrl_rdata, VECS[i].exp_rd);
            chk($sformatf("vector %0d status (R3 R7 R11)", i), {29'd0, irq_stat}, {29'd0, VECS[i].exp_st});
            chk($sformatf("vector %0d irq (R6)", i), {31'd0, irq}, {31'd0, VECS[i].exp_irq});
        end

        // R4 / R5: load, count down, expire
        step(2'd2, 32'd7);
        step(2'd0, 32'h0604_2001);
        chk("R9 counter reload with delay", ctrl_rdata, 32'h0004_2001);
        step(2'd1, 32'd0);
        chk("R4 timer loaded", ctrl_rdata, 32'h0603_2001);
        wait_delay_irq(k);
        chk("R5 expiry window", {31'd0, (k >= 20 && k <= 23)}, 32'd1);
        chk("R5 counter reload at expiry", ctrl_rdata, 32'h0004_2001);
        chk("R5 delay irq", {31'd0, irq}, 32'd1);
        repeat (12) @(negedge clk);
        chk("R5 timer stays at zero", ctrl_rdata, 32'h0004_2001);

        // R4 restart mid-count
        step(2'd2, 32'd7);
        chk("R7 clear delay bit", {29'd0, irq_stat}, 32'd0);
        step(2'd1, 32'd0);
        repeat (8) @(negedge clk);
        chk("R4 no expiry yet", {29'd0, irq_stat}, 32'd0);
        step(2'd1, 32'd0);
        chk("R4 timer restarted", ctrl_rdata, 32'h0602_2001);
        wait_delay_irq(k);
        chk("R4 expiry timed from restart", {31'd0, (k >= 20 && k <= 23)}, 32'd1);

        // R8: set and clear in the same cycle
        step(2'd0, 32'h0001_1001);
        step(2'd2, 32'd7);
        @(negedge clk);
        desc_done = 1'b1; err_evt = 1'b1; stat_we = 1'b1; stat_wclr = 3'b101;
        @(negedge clk);
        desc_done = 1'b0; err_evt = 1'b0; stat_we = 1'b0;
        chk("R8 set beats clear", {29'd0, irq_stat}, 32'd5);
        chk("R8 irq", {31'd0, irq}, 32'd1);

        finish_run();
    end
endmodule